// File: doc/BRIEF.md
# Soft-Stepping Digital Volume Control

This block scales a stereo stream of 16-bit signed audio samples by a per-channel attenuation. The attenuation is set in half-decibel steps from 0 dB down to 63.5 dB, and a mute request sends the channel to silence. The host writes a 7-bit attenuation code and a mute bit. The write goes to the left channel, to the right channel, or to both at once through a shared write strobe.

The block does not jump to a new setting. The level it applies creeps toward the requested one by a single half-decibel step for each incoming sample. A slow option halves that pace to one step every two samples. A bypass option makes the applied level follow the request on the next clock. Each channel raises a settled flag once its applied level equals its request, and a combined flag reports that both channels have settled. A host that wants silence before a disruptive change waits for this flag.

Top module: `softstep_vol`

## Requirements
- R1: After reset both channels have a muted target and a muted applied level, both settled flags and the combined flag are 1, `out_valid` is 0, and both outputs are 0.
- R2: The level code is 8 bits wide. A code n in 0..127 means n × 0.5 dB of attenuation, and code 128 means mute, which gives an output of exactly 0. A write sets the target to 128 when `wr_mute` is 1 and otherwise to `wr_att`.
- R3: `wr_l` changes only the left target and `wr_r` changes only the right target. The other channel's output and settled flag are unaffected.
- R4: `wr_both` loads the same target into both channels on the same clock edge.
- R5: With bypass off and the slow option off, each clock edge with `smp_valid` high moves the applied level one code toward the target. The level does not change on edges without a sample, and it stops when it equals the target.
- R6: With `slow_rate` high, a step happens only on every second sample. The first sample after the option is turned on does not step, and the second one does. While `slow_rate` is low the sample-pair phase is held at its start.
- R7: With `step_bypass` high, the applied level takes the target value at the next clock edge, whatever the distance.
- R8: `settled_l` and `settled_r` are 1 exactly when that channel's applied level equals its target. `settled_all` is their AND.
- R9: On each sample, the output one clock later is clamp(round((x × c) / 2^15)) with rounding half up. Here c = round(32768 × 10^(−n/40)) for the applied code n as it stood before that edge's step, and c = 0 when n = 128. The result is clamped to the 16-bit signed range. `out_valid` is high for exactly that one cycle, and the outputs hold between samples.
- R10: A new target written in the middle of a ramp redirects the ramp from the current applied level without restarting it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | A stereo sample pair is present this cycle |
| smp_l | input | 16 | Left input sample, signed |
| smp_r | input | 16 | Right input sample, signed |
| wr_l | input | 1 | Load the left target |
| wr_r | input | 1 | Load the right target |
| wr_both | input | 1 | Load both targets |
| wr_att | input | 7 | Attenuation code for a write, 0.5 dB per count |
| wr_mute | input | 1 | The write requests mute |
| slow_rate | input | 1 | Step once per two samples |
| step_bypass | input | 1 | Applied level follows the target directly |
| out_valid | output | 1 | Scaled sample pair present |
| out_l | output | 16 | Left scaled sample, signed |
| out_r | output | 16 | Right scaled sample, signed |
| settled_l | output | 1 | Left applied level equals its target |
| settled_r | output | 1 | Right applied level equals its target |
| settled_all | output | 1 | Both channels settled |

## Verification
A target write takes effect at the edge that samples it, so the settled flags change one cycle after the write. A ramp step lands at the sample's own edge, and the scaled output with `out_valid` appears one edge after the sample, computed from the level held before that step. In bypass the level reaches the target one edge after the target register changes, so two edges after the write. The bench drives inputs at the falling edge and advances its model at each rising edge from the values held before that edge. It compares every output 1 ns after the edge, and the directed scenarios count samples up to the exact one on which a settled flag must rise.

// File: rtl/svc_pkg.sv
package svc_pkg;
  localparam int unsigned ATT_W    = 7;
  localparam int unsigned LVL_W    = ATT_W + 1;
  localparam int unsigned MUTE_LVL = 1 << ATT_W;
  localparam int unsigned SMP_W    = 16;
  localparam int unsigned FRAC_W   = 15;
  localparam int unsigned COEF_W   = FRAC_W + 2;
  localparam int unsigned PROD_W   = SMP_W + COEF_W + 1;
  localparam int unsigned NCH      = 2;

  typedef logic [LVL_W-1:0] lvl_t;

  localparam lvl_t LVL_MUTE = lvl_t'(MUTE_LVL);
  localparam logic signed [PROD_W-1:0] RND_BIAS = PROD_W'(1) << (FRAC_W - 1);
  localparam logic signed [PROD_W-1:0] SMP_MAX  = PROD_W'((1 << (SMP_W - 1)) - 1);
  localparam logic signed [PROD_W-1:0] SMP_MIN  = ~SMP_MAX;

  // linear gain for code n: 10^(-n*0.5/20) in Q1.15, zero at and above mute
  function automatic logic [COEF_W-1:0] coef_of(input int unsigned n);
    real v;
    if (n >= MUTE_LVL) return '0;
    v = (10.0 ** (-(real'(n)) / 40.0)) * real'(1 << FRAC_W);
    return COEF_W'($rtoi(v + 0.5));
  endfunction

  // multiply, round half up, clamp to the sample range
  function automatic logic signed [SMP_W-1:0] scale_sample(
    input logic signed [SMP_W-1:0] x,
    input logic [COEF_W-1:0]       c
  );
    logic signed [PROD_W-1:0] p;
    p = PROD_W'(x) * PROD_W'($signed({1'b0, c}));
    p = (p + RND_BIAS) >>> FRAC_W;
    if (p > SMP_MAX) p = SMP_MAX;
    if (p < SMP_MIN) p = SMP_MIN;
    return SMP_W'(p);
  endfunction
endpackage

// File: rtl/svc_pace.sv
module svc_pace (
  input  logic clk,
  input  logic rst_n,
  input  logic smp_valid,
  input  logic slow_rate,
  output logic step_en
);
  logic phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          phase_q <= 1'b0;
    else if (!slow_rate) phase_q <= 1'b0;
    else if (smp_valid)  phase_q <= ~phase_q;
  end

  assign step_en = smp_valid & (~slow_rate | phase_q);
endmodule

// File: rtl/svc_ramp.sv
module svc_ramp
  import svc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [ATT_W-1:0] wr_att,
  input  logic             wr_mute,
  input  logic             step_en,
  input  logic             bypass,
  output lvl_t             lvl,
  output lvl_t             tgt,
  output logic             settled
);
  always_ff @(posedge clk) begin
    if (!rst_n)  tgt <= LVL_MUTE;
    else if (wr) tgt <= wr_mute ? LVL_MUTE : {1'b0, wr_att};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                     lvl <= LVL_MUTE;
    else if (bypass)                lvl <= tgt;
    else if (step_en && lvl < tgt)  lvl <= lvl + 1'b1;
    else if (step_en && lvl > tgt)  lvl <= lvl - 1'b1;
  end

  assign settled = (lvl == tgt);
endmodule

// File: rtl/svc_gain.sv
module svc_gain
  import svc_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic signed [SMP_W-1:0] x,
  input  lvl_t                    lvl,
  output logic signed [SMP_W-1:0] y
);
  localparam int unsigned ROM_N = 1 << LVL_W;

  logic [COEF_W-1:0] rom [ROM_N];
  logic [COEF_W-1:0] coef;

  for (genvar i = 0; i < ROM_N; i++) begin : g_rom
    localparam logic [COEF_W-1:0] C = coef_of(i);
    assign rom[i] = C;
  end

  assign coef = rom[lvl];

  always_ff @(posedge clk) begin
    if (!rst_n)  y <= '0;
    else if (en) y <= scale_sample(x, coef);
  end
endmodule

// File: rtl/softstep_vol.sv
module softstep_vol
  import svc_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_valid,
  input  logic signed [SMP_W-1:0] smp_l,
  input  logic signed [SMP_W-1:0] smp_r,
  input  logic                    wr_l,
  input  logic                    wr_r,
  input  logic                    wr_both,
  input  logic [ATT_W-1:0]        wr_att,
  input  logic                    wr_mute,
  input  logic                    slow_rate,
  input  logic                    step_bypass,
  output logic                    out_valid,
  output logic signed [SMP_W-1:0] out_l,
  output logic signed [SMP_W-1:0] out_r,
  output logic                    settled_l,
  output logic                    settled_r,
  output logic                    settled_all
);
  lvl_t                    lvl_a     [NCH];
  lvl_t                    tgt_a     [NCH];
  logic                    settled_a [NCH];
  logic                    wr_a      [NCH];
  logic signed [SMP_W-1:0] x_a       [NCH];
  logic signed [SMP_W-1:0] y_a       [NCH];
  logic                    step_en;

  // named copies for the checker
  lvl_t lvl_l, lvl_r, tgt_l, tgt_r;

  assign wr_a[0] = wr_l | wr_both;
  assign wr_a[1] = wr_r | wr_both;
  assign x_a[0]  = smp_l;
  assign x_a[1]  = smp_r;

  svc_pace u_pace (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .slow_rate (slow_rate),
    .step_en   (step_en)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    svc_ramp u_ramp (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (wr_a[c]),
      .wr_att  (wr_att),
      .wr_mute (wr_mute),
      .step_en (step_en),
      .bypass  (step_bypass),
      .lvl     (lvl_a[c]),
      .tgt     (tgt_a[c]),
      .settled (settled_a[c])
    );

    svc_gain u_gain (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (smp_valid),
      .x     (x_a[c]),
      .lvl   (lvl_a[c]),
      .y     (y_a[c])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= smp_valid;
  end

  assign out_l       = y_a[0];
  assign out_r       = y_a[1];
  assign settled_l   = settled_a[0];
  assign settled_r   = settled_a[1];
  assign settled_all = settled_a[0] & settled_a[1];
  assign lvl_l       = lvl_a[0];
  assign lvl_r       = lvl_a[1];
  assign tgt_l       = tgt_a[0];
  assign tgt_r       = tgt_a[1];
endmodule

// File: rtl/svc_chk.sv
module svc_chk
  import svc_pkg::*;
(
  input logic                    clk,
  input logic                    rst_n,
  input logic                    smp_valid,
  input logic                    wr_l,
  input logic                    wr_both,
  input logic                    step_bypass,
  input lvl_t                    lvl_l,
  input lvl_t                    lvl_r,
  input lvl_t                    tgt_l,
  input lvl_t                    tgt_r,
  input logic                    settled_l,
  input logic                    out_valid,
  input logic signed [SMP_W-1:0] out_l
);
  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_bypass && !smp_valid) |=> ($stable(lvl_l) && $stable(lvl_r)));

  // R5
  unit_step_l_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_bypass |=> (lvl_l == $past(lvl_l) || lvl_l == $past(lvl_l) + 1'b1
                      || lvl_l == $past(lvl_l) - 1'b1));

  // R5
  unit_step_r_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_bypass |=> (lvl_r == $past(lvl_r) || lvl_r == $past(lvl_r) + 1'b1
                      || lvl_r == $past(lvl_r) - 1'b1));

  // R10
  toward_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_bypass && lvl_l < tgt_l) |=> lvl_l >= $past(lvl_l));

  // R10
  toward_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_bypass && lvl_l > tgt_l) |=> lvl_l <= $past(lvl_l));

  // R7
  bypass_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_bypass |=> (lvl_l == $past(tgt_l) && lvl_r == $past(tgt_r)));

  // R8
  settled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (settled_l && !wr_l && !wr_both) |=> $stable(lvl_l));

  // R9
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> out_valid);

  // R9
  valid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> !out_valid);

  // R2
  mute_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && lvl_l == LVL_MUTE) |=> out_l == '0);
endmodule

bind softstep_vol svc_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .smp_valid   (smp_valid),
  .wr_l        (wr_l),
  .wr_both     (wr_both),
  .step_bypass (step_bypass),
  .lvl_l       (lvl_l),
  .lvl_r       (lvl_r),
  .tgt_l       (tgt_l),
  .tgt_r       (tgt_r),
  .settled_l   (settled_l),
  .out_valid   (out_valid),
  .out_l       (out_l)
);

// File: tb/softstep_vol_tb.sv
module softstep_vol_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid = 1'b0;
  logic signed [15:0] smp_l = '0, smp_r = '0;
  logic wr_l = 1'b0, wr_r = 1'b0, wr_both = 1'b0, wr_mute = 1'b0;
  logic [6:0] wr_att = '0;
  logic slow_rate = 1'b0, step_bypass = 1'b0;
  logic out_valid;
  logic signed [15:0] out_l, out_r;
  logic settled_l, settled_r, settled_all;

  int checks = 0;
  int errors = 0;

  int m_lvl [2];
  int m_tgt [2];
  int m_out [2];
  bit m_ov;
  bit m_phase;

  always #10 clk = ~clk;

  softstep_vol u_dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_l(smp_l), .smp_r(smp_r),
    .wr_l(wr_l), .wr_r(wr_r), .wr_both(wr_both), .wr_att(wr_att), .wr_mute(wr_mute),
    .slow_rate(slow_rate), .step_bypass(step_bypass), .out_valid(out_valid),
    .out_l(out_l), .out_r(out_r), .settled_l(settled_l), .settled_r(settled_r),
    .settled_all(settled_all)
  );

  function automatic int bcoef(int n);
    if (n >= 128) return 0;
    return $rtoi($pow(10.0, -0.025 * n) * 32768.0 + 0.5);
  endfunction

  function automatic int bscale(int x, int c);
    longint p;
    p = longint'(x) * longint'(c);
    p = (p + 64'sd16384) >>> 15;
    if (p > 32767) p = 32767;
    if (p < -32768) p = -32768;
    return int'(p);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk(out_valid == m_ov, "R9 out_valid", int'(out_valid), int'(m_ov));
    chk(int'(out_l) == m_out[0], "R9 out_l", int'(out_l), m_out[0]);
    chk(int'(out_r) == m_out[1], "R9 out_r", int'(out_r), m_out[1]);
    chk(settled_l == (m_lvl[0] == m_tgt[0]), "R8 settled_l", int'(settled_l), int'(m_lvl[0] == m_tgt[0]));
    chk(settled_r == (m_lvl[1] == m_tgt[1]), "R8 settled_r", int'(settled_r), int'(m_lvl[1] == m_tgt[1]));
    chk(settled_all == (settled_l && settled_r), "R8 settled_all", int'(settled_all), int'(settled_l && settled_r));
  endtask

  // one clock: model advances from pre-edge values, then outputs are compared
  task automatic step();
    int nl [2];
    int nt [2];
    int no [2];
    int xs [2];
    bit se, np;
    bit wc [2];
    xs[0] = int'(smp_l); xs[1] = int'(smp_r);
    wc[0] = wr_l | wr_both; wc[1] = wr_r | wr_both;
    se = smp_valid && (!slow_rate || m_phase);
    np = !slow_rate ? 1'b0 : (smp_valid ? !m_phase : m_phase);
    for (int c = 0; c < 2; c++) begin
      no[c] = smp_valid ? bscale(xs[c], bcoef(m_lvl[c])) : m_out[c];
      if (step_bypass) nl[c] = m_tgt[c];
      else if (se && m_lvl[c] < m_tgt[c]) nl[c] = m_lvl[c] + 1;
      else if (se && m_lvl[c] > m_tgt[c]) nl[c] = m_lvl[c] - 1;
      else nl[c] = m_lvl[c];
      nt[c] = wc[c] ? (wr_mute ? 128 : int'(wr_att)) : m_tgt[c];
    end
    @(posedge clk);
    #1;
    for (int c = 0; c < 2; c++) begin
      m_lvl[c] = nl[c]; m_tgt[c] = nt[c]; m_out[c] = no[c];
    end
    m_ov = smp_valid;
    m_phase = np;
    compare_all();
    @(negedge clk);
    smp_valid = 1'b0; wr_l = 1'b0; wr_r = 1'b0; wr_both = 1'b0;
  endtask

  task automatic samples(int n);
    for (int i = 0; i < n; i++) begin
      smp_valid = 1'b1;
      smp_l = 16'($urandom);
      smp_r = 16'($urandom);
      step();
    end
  endtask

  task automatic write(bit l, bit r, bit both, int att, bit mute);
    wr_l = l; wr_r = r; wr_both = both; wr_att = 7'(att); wr_mute = mute;
    step();
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'h1357_2468));
    for (int c = 0; c < 2; c++) begin
      m_lvl[c] = 128; m_tgt[c] = 128; m_out[c] = 0;
    end
    m_ov = 1'b0; m_phase = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(settled_all === 1'b1, "R1 settled_all", int'(settled_all), 1);
    chk(out_valid === 1'b0 && out_l === '0 && out_r === '0, "R1 outputs", int'(out_l), 0);

    // R2: muted level gives zero even for a full-scale sample
    smp_valid = 1'b1; smp_l = 16'sh7fff; smp_r = -16'sh8000;
    step();
    chk(out_l == 0 && out_r == 0, "R2 mute output", int'(out_l), 0);

    // R3/R5: left ramps from mute to 0 dB in 128 samples, right untouched
    write(1, 0, 0, 0, 0);
    chk(settled_r == 1'b1, "R3 right settled", int'(settled_r), 1);
    samples(127);
    chk(settled_l == 1'b0, "R5 not yet settled", int'(settled_l), 0);
    samples(1);
    chk(settled_l == 1'b1, "R5 settled after 128", int'(settled_l), 1);
    chk(out_r == 0, "R3 right still muted", int'(out_r), 0);
    // R5: no step without a sample
    write(1, 0, 0, 3, 0);
    repeat (5) step();
    chk(settled_l == 1'b0, "R5 idle no step", int'(settled_l), 0);
    samples(3);
    chk(settled_l == 1'b1, "R5 reaches 3", int'(settled_l), 1);

    // R9: full-scale sample at 0 dB passes untouched
    write(1, 0, 0, 0, 0);
    samples(3);
    smp_valid = 1'b1; smp_l = 16'sh7fff; smp_r = 16'sh1234;
    step();
    chk(int'(out_l) == 32767, "R9 unity gain", int'(out_l), 32767);

    // R6: slow rate, 10 codes need 20 samples
    slow_rate = 1'b1;
    step();
    write(1, 0, 0, 10, 0);
    samples(19);
    chk(settled_l == 1'b0, "R6 slow 19", int'(settled_l), 0);
    samples(1);
    chk(settled_l == 1'b1, "R6 slow 20", int'(settled_l), 1);
    slow_rate = 1'b0;
    step();

    // R10: redirect mid ramp from 10 toward 50, then back to 15
    write(1, 0, 0, 50, 0);
    samples(10);
    write(1, 0, 0, 15, 0);
    samples(4);
    chk(settled_l == 1'b0, "R10 redirect 4", int'(settled_l), 0);
    samples(1);
    chk(settled_l == 1'b1, "R10 redirect 5", int'(settled_l), 1);

    // R4: master write loads both channels
    write(0, 0, 1, 20, 0);
    chk(settled_l == 1'b0 && settled_r == 1'b0, "R4 both targets", int'(settled_all), 0);
    samples(108);
    chk(settled_all == 1'b1, "R4 both settled", int'(settled_all), 1);

    // R7: bypass jump
    step_bypass = 1'b1;
    write(0, 1, 0, 100, 0);
    chk(settled_r == 1'b0, "R7 one edge after write", int'(settled_r), 0);
    step();
    chk(settled_r == 1'b1, "R7 jumped", int'(settled_r), 1);
    step_bypass = 1'b0;
    step();

    // R2: ramp into mute on left
    write(1, 0, 0, 0, 1);
    samples(107);
    chk(settled_l == 1'b0, "R2 mute not yet", int'(settled_l), 0);
    samples(1);
    chk(settled_l == 1'b1, "R2 mute reached", int'(settled_l), 1);
    samples(1);
    chk(out_l == 0, "R2 muted output", int'(out_l), 0);

    // random mix, checked every cycle against the model
    for (int i = 0; i < 4000; i++) begin
      smp_valid = ($urandom_range(0, 2) != 0);
      smp_l = 16'($urandom); smp_r = 16'($urandom);
      if ($urandom_range(0, 3) == 0) smp_l = ($urandom_range(0, 1) != 0) ? 16'sh7fff : -16'sh8000;
      wr_l = ($urandom_range(0, 30) == 0);
      wr_r = ($urandom_range(0, 30) == 0);
      wr_both = ($urandom_range(0, 60) == 0);
      wr_att = 7'($urandom);
      wr_mute = ($urandom_range(0, 7) == 0);
      if ($urandom_range(0, 200) == 0) slow_rate = ~slow_rate;
      if ($urandom_range(0, 300) == 0) step_bypass = ~step_bypass;
      step();
    end
    summary();
  end
endmodule